// File: doc/BRIEF.md
# Bit-Sliced Integer ALU

This block is a purely combinational integer arithmetic and logic unit for a configurable word width (32 bits by default). It is built from a chain of identical one-bit slices. Each slice holds an AND gate, an OR gate and a full adder, and picks one of them, or a less-than input, through a four-way selector. The slices are linked by a ripple carry.

The 4-bit operation code is decoded one bit at a time, not through an opcode table:
- Bit 3 complements operand A before it enters the slices.
- Bit 2 complements operand B and also supplies the carry into the lowest slice.
- Bits 1:0 drive every slice's output selector.

As a result, subtraction is A + ~B + 1, and NOR and NAND follow from De Morgan's laws on the AND and OR paths.

A signed comparison sends the corrected sign of A − B back into slice 0. A zero flag marks an all-zero result, which a datapath uses to test for equality. The block has no clock and no state. Its outputs follow its inputs in the same evaluation.

Top module: `bsl_alu`

## Requirements
- R1: Operation code 4'b0000 gives result = A AND B, bit by bit.
- R2: Operation code 4'b0001 gives result = A OR B, bit by bit.
- R3: Operation code 4'b0010 gives result = (A + B) modulo 2^WIDTH, with the carry rippling across every bit position.
- R4: Operation code 4'b0110 gives result = (A − B) modulo 2^WIDTH.
- R5: Operation code 4'b0111 gives a result of 1 when A is less than B as two's-complement signed numbers, and 0 otherwise. All result bits above bit 0 are zero. This holds for every operand pair, including pairs whose difference overflows.
- R6: Operation code 4'b1100 gives result = NOT (A OR B).
- R7: Operation code 4'b1101 gives result = NOT (A AND B).
- R8: Every operation code other than the seven above gives an all-zero result.
- R9: The zero flag is 1 exactly when every result bit is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | WIDTH | First operand |
| b_i | input | WIDTH | Second operand |
| op_i | input | 4 | Operation code; bit 3 inverts A, bit 2 inverts B and sets carry-in, bits 1:0 select the slice path |
| result_o | output | WIDTH | Operation result |
| zero_o | output | 1 | High when result_o is all zeros |

## Verification
The block holds no state, so any internal fault appears on result_o or zero_o as soon as the inputs change. A fault can stay hidden, however, until the operands exercise it. A broken carry link only shows when a carry must cross that particular slice, which is why all-ones, most-negative and most-positive operands are applied next to random ones. A wrong overflow correction in the less-than path only appears when A − B overflows. That is why signed comparisons between the extreme values are applied explicitly.

// File: rtl/bsl_alu_pkg.sv
package bsl_alu_pkg;

   typedef enum logic [3:0] {
      OP_AND  = 4'b0000,
      OP_OR   = 4'b0001,
      OP_ADD  = 4'b0010,
      OP_SUB  = 4'b0110,
      OP_SLT  = 4'b0111,
      OP_NOR  = 4'b1100,
      OP_NAND = 4'b1101
   } alu_op_e;

   // Slice output selector values (operation bits 1:0)
   localparam logic [1:0] SEL_AND  = 2'b00;
   localparam logic [1:0] SEL_OR   = 2'b01;
   localparam logic [1:0] SEL_SUM  = 2'b10;
   localparam logic [1:0] SEL_LESS = 2'b11;

   function automatic logic op_is_legal(input logic [3:0] op);
      case (op)
         OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NOR, OP_NAND: op_is_legal = 1'b1;
         default:                                                op_is_legal = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/bsl_alu_decode.sv
module bsl_alu_decode
   import bsl_alu_pkg::*;
(
   input  logic [3:0] op_i,
   output logic       a_inv_o,
   output logic       b_inv_o,
   output logic [1:0] sel_o,
   output logic       legal_o
);

   // Bit-wise decode: each control comes straight from one opcode field
   assign a_inv_o = op_i[3];
   assign b_inv_o = op_i[2];
   assign sel_o   = op_i[1:0];
   assign legal_o = op_is_legal(op_i);

endmodule

// File: rtl/bsl_alu_slice.sv
module bsl_alu_slice
   import bsl_alu_pkg::*;
#(
   parameter bit IS_MSB = 1'b0
) (
   input  logic       a_i,
   input  logic       b_i,
   input  logic       a_inv_i,
   input  logic       b_inv_i,
   input  logic       cin_i,
   input  logic       less_i,
   input  logic [1:0] sel_i,
   output logic       res_o,
   output logic       cout_o,
   output logic       set_o
);

   logic a_eff, b_eff, sum;

   assign a_eff  = a_i ^ a_inv_i;
   assign b_eff  = b_i ^ b_inv_i;
   assign sum    = a_eff ^ b_eff ^ cin_i;
   assign cout_o = (a_eff & cin_i) | (b_eff & cin_i) | (a_eff & b_eff);

   always_comb begin
      case (sel_i)
         SEL_AND:  res_o = a_eff & b_eff;
         SEL_OR:   res_o = a_eff | b_eff;
         SEL_SUM:  res_o = sum;
         default:  res_o = less_i;
      endcase
   end

   // Only the top slice produces the overflow-corrected sign
   if (IS_MSB) begin : g_msb
      assign set_o = sum ^ (cin_i ^ cout_o);
   end else begin : g_plain
      assign set_o = 1'b0;
   end

endmodule

// File: rtl/bsl_alu_zero.sv
module bsl_alu_zero #(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] vec_i,
   output logic             zero_o
);

   assign zero_o = ~|vec_i;

endmodule

// File: rtl/bsl_alu.sv
module bsl_alu
   import bsl_alu_pkg::*;
#(
   parameter int WIDTH = 32
) (
   input  logic [WIDTH-1:0] a_i,
   input  logic [WIDTH-1:0] b_i,
   input  logic [3:0]       op_i,
   output logic [WIDTH-1:0] result_o,
   output logic             zero_o
);

   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_bad_width
      $error("bsl_alu: WIDTH must be at least 2");
   end

   logic             a_inv, b_inv, legal;
   logic [1:0]       sel;
   logic [WIDTH-1:0] raw;
   logic [WIDTH-1:0] set_vec;
   logic             less0;

   bsl_alu_decode i_decode (
      .op_i    (op_i),
      .a_inv_o (a_inv),
      .b_inv_o (b_inv),
      .sel_o   (sel),
      .legal_o (legal)
   );

   // Only the MSB slice drives a nonzero set bit
   assign less0 = |set_vec;

   for (genvar i = 0; i < WIDTH; i++) begin : g_slice
      logic cin, cout, less;
      if (i == 0) begin : g_first
         assign cin  = b_inv;
         assign less = less0;
      end else begin : g_next
         assign cin  = g_slice[i-1].cout;
         assign less = 1'b0;
      end
      bsl_alu_slice #(.IS_MSB(i == MSB)) i_slice (
         .a_i     (a_i[i]),
         .b_i     (b_i[i]),
         .a_inv_i (a_inv),
         .b_inv_i (b_inv),
         .cin_i   (cin),
         .less_i  (less),
         .sel_i   (sel),
         .res_o   (raw[i]),
         .cout_o  (cout),
         .set_o   (set_vec[i])
      );
   end

   assign result_o = legal ? raw : '0;

   bsl_alu_zero #(.WIDTH(WIDTH)) i_zero (
      .vec_i  (result_o),
      .zero_o (zero_o)
   );

   // Behavioural cross-checks of the ripple structure
   always_comb begin
      case (op_i)
         OP_AND:  a_r1_and:  assert (result_o == (a_i & b_i)) else $error("R1 AND mismatch");
         OP_OR:   a_r2_or:   assert (result_o == (a_i | b_i)) else $error("R2 OR mismatch");
         OP_ADD:  a_r3_add:  assert (result_o == WIDTH'(a_i + b_i)) else $error("R3 add mismatch");
         OP_SUB:  a_r4_sub:  assert (result_o == WIDTH'(a_i - b_i)) else $error("R4 sub mismatch");
         OP_SLT:  a_r5_slt:  assert (result_o == {{(WIDTH-1){1'b0}}, ($signed(a_i) < $signed(b_i))})
                                else $error("R5 slt mismatch");
         OP_NOR:  a_r6_nor:  assert (result_o == ~(a_i | b_i)) else $error("R6 NOR mismatch");
         OP_NAND: a_r7_nand: assert (result_o == ~(a_i & b_i)) else $error("R7 NAND mismatch");
         default: a_r8_illegal: assert (result_o == '0 && zero_o) else $error("R8 illegal code not zero");
      endcase
      a_r9_zero: assert (zero_o == (result_o == '0)) else $error("R9 zero flag mismatch");
   end

endmodule

// File: tb/test_bsl_alu.sv
module test_bsl_alu;

   localparam int W = 32;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] a, b;
   logic [3:0]   op;
   logic [W-1:0] res;
   logic         zero;

   int n_checks = 0;
   int n_fail   = 0;
   int cycles   = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   bsl_alu #(.WIDTH(W)) i_bsl_alu (
      .a_i(a), .b_i(b), .op_i(op), .result_o(res), .zero_o(zero)
   );

   function automatic logic [W-1:0] model(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
      case (o)
         4'b0000: model = x & y;
         4'b0001: model = x | y;
         4'b0010: model = x + y;
         4'b0110: model = x - y;
         4'b0111: model = ($signed(x) < $signed(y)) ? W'(1) : W'(0);
         4'b1100: model = ~(x | y);
         4'b1101: model = ~(x & y);
         default: model = '0;
      endcase
   endfunction

   function automatic string req_of(input logic [3:0] o);
      case (o)
         4'b0000: req_of = "R1";
         4'b0001: req_of = "R2";
         4'b0010: req_of = "R3";
         4'b0110: req_of = "R4";
         4'b0111: req_of = "R5";
         4'b1100: req_of = "R6";
         4'b1101: req_of = "R7";
         default: req_of = "R8";
      endcase
   endfunction

   task automatic apply(input logic [3:0] o, input logic [W-1:0] x, input logic [W-1:0] y);
      logic [W-1:0] exp_r;
      @(posedge clk);
      op = o; a = x; b = y;
      @(negedge clk);
      exp_r = model(o, x, y);
      n_checks++;
      if (res !== exp_r) begin
         n_fail++;
         $display("FAIL %s op=%b a=%h b=%h result actual=%h expected=%h", req_of(o), o, x, y, res, exp_r);
      end
      n_checks++;
      if (zero !== (exp_r == '0)) begin
         n_fail++;
         $display("FAIL R9 op=%b a=%h b=%h zero actual=%b expected=%b", o, x, y, zero, (exp_r == '0));
      end
   endtask

   task automatic finish_up();
      if (!finished) begin
         finished = 1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 150000) begin
         n_fail++;
         $display("FAIL watchdog expired");
         finish_up();
      end
   end

   initial begin
      logic [W-1:0] corners [6];
      logic [3:0]   legal_ops [7];
      corners   = '{32'h0, 32'hFFFF_FFFF, 32'h8000_0000, 32'h7FFF_FFFF, 32'h1, 32'h5555_AAAA};
      legal_ops = '{4'b0000, 4'b0001, 4'b0010, 4'b0110, 4'b0111, 4'b1100, 4'b1101};
      op = 4'b0000; a = '0; b = '0;
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      rst = 1'b0;

      // Quiescent state: AND of zeros gives zero result, zero flag high (R1, R9)
      apply(4'b0000, '0, '0);

      // R3 carry across full width, R4 borrow across full width
      apply(4'b0010, 32'hFFFF_FFFF, 32'h1);
      apply(4'b0110, 32'h0, 32'h1);
      // R5 overflow cases: most-negative vs most-positive
      apply(4'b0111, 32'h8000_0000, 32'h7FFF_FFFF);
      apply(4'b0111, 32'h7FFF_FFFF, 32'h8000_0000);
      apply(4'b0111, 32'h5, 32'h5);
      // R8: every unlisted code on all-ones operands must give zero
      for (int c = 0; c < 16; c++) apply(4'(c), 32'hFFFF_FFFF, 32'hFFFF_FFFF);

      // Every legal op over every corner pair (R1..R7)
      foreach (legal_ops[k])
         foreach (corners[i])
            foreach (corners[j])
               apply(legal_ops[k], corners[i], corners[j]);

      // Constrained random: mostly legal codes, some arbitrary codes
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] o;
         if ($urandom_range(0, 7) == 0) o = 4'($urandom);
         else o = legal_ops[$urandom_range(0, 6)];
         apply(o, $urandom, (n % 5 == 0) ? $urandom_range(0, 3) : $urandom);
      end

      finish_up();
   end

endmodule